// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a 30-bit physical address with one lookup in a flat, single-level page table held in memory. A requester hands over a virtual address and an access kind (read, write or execute). The walker takes the upper bits of the address as a table index, scales it to a byte offset and adds it to a table base register. It then fetches that one word through a request/response memory port and decodes it. The result is either a physical address or a fault code.

A fault code tells a missing page apart from a page that is present but does not allow the requested access. Software selects the active address space by loading the base register. A load that arrives while a lookup is under way is held back until that lookup's result has been taken, so a lookup never sees two different bases. Only one lookup is in progress at a time. The request side and the result side each use a valid/ready handshake.

Top module: `page_walker`

## Requirements
- R1: The low 10 bits of the virtual address are a page offset, copied unchanged into the low 10 bits of a successful physical address. The upper 22 bits are the virtual page number.
- R2: Each accepted request causes exactly one memory read, at address base + page number × 4 (modulo 2^32). The read request stays asserted with a stable address until the memory accepts it.
- R3: A table entry is one 32-bit word: bit 31 valid, bit 30 read allowed, bit 29 write allowed, bit 28 execute allowed, bits 19..0 the physical page number. Bits 27..20 are ignored. A permitted access returns {page number, offset}.
- R4: An entry with bit 31 clear yields fault code 1 (page fault), whatever its rights bits hold.
- R5: The access kind is encoded as 0 = read, 1 = write, 2 = execute and 3 = reserved. On a valid entry whose matching rights bit is clear, or for code 3, the result is fault code 2 (protection fault).
- R6: Fault code 0 means success, and code 3 is never produced. The physical address output is zero whenever the fault code is non-zero.
- R7: The walker accepts a request only while no lookup is in progress. A presented result keeps its value until the requester takes it.
- R8: A base load made while idle applies to the next request. A load made during a lookup does not affect that lookup. It takes effect once the result is taken, and the last such load wins.
- R9: After reset the walker is idle and ready, presents no memory request and no result, and the base register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseWrEn | input | 1 | Load the table base register |
| baseWrData | input | 32 | New table base byte address |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker can take a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| memReqValid | output | 1 | Table read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Byte address of the table entry |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Table entry word |
| resValid | output | 1 | Translation result present |
| resReady | input | 1 | Requester takes the result |
| resPaddr | output | 30 | Physical address, zero on a fault |
| resFault | output | 2 | 0 none, 1 page fault, 2 protection fault |

## Verification
A corrupted base register or page-number latch shows up at the memory port as a wrong read address. That happens in the cycle the read is issued, one cycle after the request is accepted, before any result exists. A wrong captured entry or access kind shows up one cycle after the response as a wrong fault code or physical address. A deferred base load that is lost or applied early is only exposed by the next lookup's read address. For that reason, base loads are interleaved with lookups that hit different table regions. Controller states that do not match the handshakes appear as a ready request port during a lookup, or as a result that changes while stalled.

// File: rtl/page_walker_pkg.sv
package page_walker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;    // capture virtual address and access kind
    logic latchEntry;  // capture decoded result from the response
    logic baseOpen;    // base register may be updated this cycle
  } walkStrobe_t;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [1:0] FLT_NONE  = 2'd0;
  localparam logic [1:0] FLT_PAGE  = 2'd1;
  localparam logic [1:0] FLT_PROT  = 2'd2;

endpackage

// File: rtl/page_walker_ctrl.sv
module page_walker_ctrl
  import page_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        resReady,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        resValid,
  output walkStrobe_t strobe
);

  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (reqValid)    stateNext = ST_ISSUE;
      ST_ISSUE: if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT:  if (memRspValid) stateNext = ST_DONE;
      ST_DONE:  if (resReady)    stateNext = ST_IDLE;
      default:                   stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_ISSUE);
  assign resValid    = (state == ST_DONE);

  always_comb begin
    strobe.latchReq   = (state == ST_IDLE) && reqValid;
    strobe.latchEntry = (state == ST_WAIT) && memRspValid;
    strobe.baseOpen   = (state == ST_IDLE) || ((state == ST_DONE) && resReady);
  end

endmodule

// File: rtl/page_walker_dp.sv
module page_walker_dp
  import page_walker_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 30,
  parameter int OFF_W       = 10,
  parameter int ENT_W       = 32,
  parameter int ENTRY_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic              baseWrEn,
  input  logic [VA_W-1:0]   baseWrData,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic [ENT_W-1:0]  memRspData,
  output logic [VA_W-1:0]   memReqAddr,
  output logic [PA_W-1:0]   resPaddr,
  output logic [1:0]        resFault
);

  localparam int PPN_W     = PA_W - OFF_W;
  localparam int IDX_SHIFT = $clog2(ENTRY_BYTES);
  localparam int VALID_BIT = ENT_W - 1;
  localparam int RD_BIT    = ENT_W - 2;
  localparam int WR_BIT    = ENT_W - 3;
  localparam int EX_BIT    = ENT_W - 4;

  logic [VA_W-1:0]  baseReg;
  logic [VA_W-1:0]  pendData;
  logic             pendValid;
  logic [VA_W-1:0]  vaReg;
  logic [1:0]       accReg;
  logic [PA_W-1:0]  paReg;
  logic [1:0]       faultReg;

  // base register with deferral of loads that arrive mid-lookup
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg   <= '0;
      pendData  <= '0;
      pendValid <= 1'b0;
    end else if (strobe.baseOpen) begin
      if (baseWrEn)       baseReg <= baseWrData;
      else if (pendValid) baseReg <= pendData;
      pendValid <= 1'b0;
    end else if (baseWrEn) begin
      pendData  <= baseWrData;
      pendValid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg  <= '0;
      accReg <= ACC_READ;
    end else if (strobe.latchReq) begin
      vaReg  <= reqVaddr;
      accReg <= reqAccess;
    end
  end

  // entry address: base plus scaled page number
  logic [VA_W-1:0] idxBytes;
  assign idxBytes   = VA_W'(vaReg[VA_W-1:OFF_W]) << IDX_SHIFT;
  assign memReqAddr = baseReg + idxBytes;

  // entry decode and permission check
  logic             rightOk;
  logic [1:0]       faultNext;
  logic [PA_W-1:0]  paNext;
  logic             unusedEntryBits;

  assign unusedEntryBits = ^memRspData[EX_BIT-1:PPN_W];

  always_comb begin
    case (accReg)
      ACC_READ:  rightOk = memRspData[RD_BIT];
      ACC_WRITE: rightOk = memRspData[WR_BIT];
      ACC_EXEC:  rightOk = memRspData[EX_BIT];
      default:   rightOk = 1'b0;
    endcase
    if (!memRspData[VALID_BIT]) begin
      faultNext = FLT_PAGE;
      paNext    = '0;
    end else if (!rightOk) begin
      faultNext = FLT_PROT;
      paNext    = '0;
    end else begin
      faultNext = FLT_NONE;
      paNext    = {memRspData[PPN_W-1:0], vaReg[OFF_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paReg    <= '0;
      faultReg <= FLT_NONE;
    end else if (strobe.latchEntry) begin
      paReg    <= paNext;
      faultReg <= faultNext;
    end
  end

  assign resPaddr = paReg;
  assign resFault = faultReg;

endmodule

// File: rtl/page_walker.sv
module page_walker
  import page_walker_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 30,
  parameter int OFF_W       = 10,
  parameter int ENT_W       = 32,
  parameter int ENTRY_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWrEn,
  input  logic [VA_W-1:0]   baseWrData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [VA_W-1:0]   memReqAddr,
  input  logic              memRspValid,
  input  logic [ENT_W-1:0]  memRspData,
  output logic              resValid,
  input  logic              resReady,
  output logic [PA_W-1:0]   resPaddr,
  output logic [1:0]        resFault
);

  walkStrobe_t strobe;

  page_walker_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .resReady    (resReady),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .resValid    (resValid),
    .strobe      (strobe)
  );

  page_walker_dp #(
    .VA_W        (VA_W),
    .PA_W        (PA_W),
    .OFF_W       (OFF_W),
    .ENT_W       (ENT_W),
    .ENTRY_BYTES (ENTRY_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .baseWrEn   (baseWrEn),
    .baseWrData (baseWrData),
    .reqVaddr   (reqVaddr),
    .reqAccess  (reqAccess),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .resPaddr   (resPaddr),
    .resFault   (resFault)
  );

endmodule

// File: rtl/page_walker_checker.sv
module page_walker_checker #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFF_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [VA_W-1:0]  reqVaddr,
  input logic             memReqValid,
  input logic             memReqReady,
  input logic [VA_W-1:0]  memReqAddr,
  input logic             resValid,
  input logic             resReady,
  input logic [PA_W-1:0]  resPaddr,
  input logic [1:0]       resFault
);

  logic [OFF_W-1:0] ckOff;

  always_ff @(posedge clk) begin
    if (!rstN) ckOff <= '0;
    else if (reqValid && reqReady) ckOff <= reqVaddr[OFF_W-1:0];
  end

  // R1: a successful result carries the offset of the accepted request
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    resValid && (resFault == 2'd0) |-> resPaddr[OFF_W-1:0] == ckOff);

  // R2: a stalled memory read holds its request and address
  a_r2_read_held: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R6: no address leaks out on a fault
  a_r6_zero_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    resValid && (resFault != 2'd0) |-> resPaddr == '0);

  // R6: fault code 3 is never produced
  a_r6_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> resFault != 2'd3);

  // R7: a stalled result does not change
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady |=> resValid && $stable(resPaddr) && $stable(resFault));

  // R7: no new request is taken while a lookup is under way
  a_r7_one_at_a_time: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid && !resValid);

endmodule

bind page_walker page_walker_checker #(
  .VA_W  (VA_W),
  .PA_W  (PA_W),
  .OFF_W (OFF_W)
) u_checker (.*);

// File: tb/page_walker_bench.sv
module page_walker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        resValid;
  logic        resReady = 1'b0;
  logic [29:0] resPaddr;
  logic [1:0]  resFault;

  always #10 clk = ~clk;  // 50 MHz

  page_walker u_page_walker (
    .clk(clk), .rstN(rstN), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqAccess(reqAccess),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .resValid(resValid), .resReady(resReady), .resPaddr(resPaddr), .resFault(resFault)
  );

  typedef struct {
    logic [31:0] addr;
    logic [29:0] pa;
    logic [1:0]  flt;
    string       tag;
  } expItem_t;

  expItem_t    resQ[$];
  expItem_t    addrQ[$];
  logic [31:0] ptMem [logic [31:0]];
  logic [31:0] modelBase = '0;
  int          checks = 0;
  int          fails = 0;
  int          reqCount = 0;
  int          readCount = 0;
  bit          done = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pte(input bit v, input bit r, input bit w,
                                      input bit x, input logic [19:0] ppn);
    return {v, r, w, x, 8'h5A, ppn};  // filler in ignored bits (R3)
  endfunction

  function automatic expItem_t predict(input logic [31:0] va, input logic [1:0] acc,
                                       input string tag);
    expItem_t    it;
    logic [31:0] e;
    bit          ok;
    it.addr = modelBase + {va[31:10], 2'b00};
    e = ptMem.exists(it.addr) ? ptMem[it.addr] : 32'h0;
    case (acc)
      2'd0: ok = e[30];
      2'd1: ok = e[29];
      2'd2: ok = e[28];
      default: ok = 1'b0;
    endcase
    if (!e[31]) begin it.flt = 2'd1; it.pa = '0; end
    else if (!ok) begin it.flt = 2'd2; it.pa = '0; end
    else begin it.flt = 2'd0; it.pa = {e[19:0], va[9:0]}; end
    it.tag = tag;
    return it;
  endfunction

  // driver: called at a negative edge, returns at the negative edge after acceptance
  task automatic request(input logic [31:0] va, input logic [1:0] acc, input string tag);
    expItem_t it;
    it = predict(va, acc, tag);
    resQ.push_back(it);
    addrQ.push_back(it);
    reqCount++;
    reqVaddr  = va;
    reqAccess = acc;
    reqValid  = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " R7 busy"}, {63'd0, reqReady}, 64'd0);
  endtask

  task automatic loadBase(input logic [31:0] b);
    baseWrEn   = 1'b1;
    baseWrData = b;
    @(negedge clk);
    baseWrEn   = 1'b0;
  endtask

  task automatic waitIdle();
    while (resQ.size() != 0 || !reqReady) @(negedge clk);
  endtask

  // memory model with request stalls and variable response delay
  initial begin
    int          stall = 0;
    int          delay = 0;
    bit          pend = 1'b0;
    logic [31:0] rdata = '0;
    expItem_t    a;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (pend) begin
        if (delay == 0) begin
          memRspValid = 1'b1;
          memRspData  = rdata;
          pend = 1'b0;
        end else delay--;
      end
      stall++;
      memReqReady = (stall % 3) != 0;
      if (rstN && memReqValid && memReqReady) begin
        readCount++;
        if (addrQ.size() == 0) check("R2 unexpected read", {32'd0, memReqAddr}, 64'd0);
        else begin
          a = addrQ.pop_front();
          check({a.tag, " R2 entry address"}, {32'd0, memReqAddr}, {32'd0, a.addr});
        end
        rdata = ptMem.exists(memReqAddr) ? ptMem[memReqAddr] : 32'h0;
        pend  = 1'b1;
        delay = stall % 2;
      end
    end
  end

  // monitor: result scoreboard and stall stability
  initial begin
    int          cyc = 0;
    bit          held = 1'b0;
    logic [31:0] heldVal = '0;
    expItem_t    e;
    forever begin
      @(negedge clk);
      cyc++;
      if (held) check("R7 result held", {32'd0, resValid, resFault, resPaddr},
                      {32'd0, 1'b1, heldVal[31:0]});
      resReady = (cyc % 4) != 1;
      held = 1'b0;
      if (rstN && resValid) begin
        if (!resReady) begin
          held = 1'b1;
          heldVal = {resFault, resPaddr};
        end else if (resQ.size() == 0) begin
          check("R7 unexpected result", {32'd0, resFault, resPaddr}, 64'd0);
        end else begin
          e = resQ.pop_front();
          check(e.tag, {32'd0, resFault, resPaddr}, {32'd0, e.flt, e.pa});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // table contents (R3): entries under three bases
    ptMem[32'h0000_0014] = pte(1, 1, 0, 0, 20'hABCDE);
    ptMem[32'h0004_0004] = pte(1, 1, 1, 1, 20'h11111);
    ptMem[32'h0004_0008] = pte(1, 1, 0, 0, 20'h22222);
    ptMem[32'h0004_000C] = pte(0, 1, 1, 1, 20'h33333);
    ptMem[32'h0004_0010] = pte(1, 0, 1, 1, 20'h44444);
    ptMem[32'h0004_0000 + 32'h00FF_FFFC] = pte(1, 1, 0, 0, 20'hFFFFF);
    ptMem[32'h0008_0004] = pte(1, 0, 0, 1, 20'h55555);
    ptMem[32'h000C_0004] = pte(1, 1, 1, 0, 20'h66666);

    repeat (3) @(negedge clk);
    check("R9 ready in reset", {61'd0, reqReady, memReqValid, resValid}, {61'd0, 3'b100});
    rstN = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {61'd0, reqReady, memReqValid, resValid}, {61'd0, 3'b100});

    // R9: base is zero after reset
    request({22'd5, 10'h123}, 2'd0, "R9 zero base read");
    waitIdle();

    loadBase(32'h0004_0000);
    modelBase = 32'h0004_0000;
    request({22'd1, 10'h001}, 2'd0, "R3 read allowed");
    request({22'd1, 10'h2AA}, 2'd1, "R3 write allowed");
    request({22'd1, 10'h155}, 2'd2, "R3 exec allowed");
    request({22'd2, 10'h010}, 2'd1, "R5 write on read-only");
    request({22'd2, 10'h020}, 2'd2, "R5 exec without X");
    request({22'd2, 10'h030}, 2'd0, "R5 read on read-only");
    request({22'd4, 10'h040}, 2'd0, "R5 read without R");
    request({22'd1, 10'h050}, 2'd3, "R5 reserved access");
    request({22'd3, 10'h060}, 2'd0, "R4 invalid with rights");
    request({22'd3, 10'h070}, 2'd3, "R4 invalid beats reserved");
    request({22'd7, 10'h080}, 2'd1, "R4 empty entry");
    request({22'h3FFFFF, 10'h3FF}, 2'd0, "R1 top page top offset");
    request({22'd1, 10'h000}, 2'd2, "R6 success at zero offset");
    waitIdle();

    // R8: loads during a lookup are deferred, last one wins
    request({22'd1, 10'h0F0}, 2'd0, "R8 lookup keeps old base");
    baseWrEn = 1'b1; baseWrData = 32'h0008_0000;
    @(negedge clk);
    baseWrData = 32'h000C_0000;
    @(negedge clk);
    baseWrEn = 1'b0;
    modelBase = 32'h000C_0000;
    request({22'd1, 10'h0F1}, 2'd1, "R8 deferred last load applied");
    request({22'd1, 10'h0F2}, 2'd2, "R8 exec under new base");
    waitIdle();
    loadBase(32'h0008_0000);
    modelBase = 32'h0008_0000;
    request({22'd1, 10'h0F3}, 2'd2, "R8 idle load applied");
    waitIdle();

    repeat (4) @(negedge clk);
    check("R2 one read per request", {32'd0, readCount}, {32'd0, reqCount});
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule